// File: doc/BRIEF.md
# Three-Wire Serial Bus Slave Controller

This block is the slave end of a three-pin serial link: an active-low select, a bus clock and one shared data pin. Every transaction opens with a 9-bit header sent most significant bit first, which names one of eight attached register devices, a register within it and whether the access reads or writes. A 16-bit word follows, most significant bit first. For a write, the master shifts the word in. For a read, the slave turns the data pin around and shifts the word out.

All three pins are asynchronous to the system clock. Each pin passes through a two-stage synchronizer, and the bus clock's rising and falling edges are detected in the system clock domain. Each bus clock level must therefore be held for at least three system clock cycles.

On the register side, the block issues a one-cycle request that carries the device, the register, a read flag and the write data. Read data is returned combinationally by the addressed device and captured in the request cycle. A read is requested as soon as the header is complete. A write is requested once the last data bit has arrived. An access to a device that is not marked present issues no request and sets a sticky error flag instead.

Top module: `tws_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `req_valid_o`, `bus_dat_oe_o`, `bus_dat_o` and `err_o` are all 0.
- R2: Header bits are taken MSB first on rising bus clock edges while select is low. Header bits 8..6 form the device number, bit 5 is the read flag (1 = read), and bits 4..0 form the register number. A request presents exactly these fields on `req_dev_o`, `req_rd_o` and `req_reg_o`.
- R3: For a read to a present device, exactly one request with `req_rd_o` = 1 is issued after the 9th header bit. `rd_data_i` is captured in the cycle `req_valid_o` is high. On the next 16 rising bus clock edges, the captured word is driven on `bus_dat_o`, starting with bit 15.
- R4: For a write to a present device, 16 data bits are shifted in MSB first. Exactly one request with `req_rd_o` = 0 and `req_wdata_o` equal to that word is issued after the 16th bit, and no request is issued before it.
- R5: Bus clock edges while select is high have no effect. Raising select at any point abandons the transaction, and the next transaction starts again at header bit 8.
- R6: After the 16th data bit, the block returns to the header phase, so several transactions can follow one another without select being released.
- R7: An access to a device whose bit in `dev_present_i` is 0 issues no request and sets `err_o`. `err_o` then stays 1 until reset. A read of such a device drives all-zero data.
- R8: `bus_dat_oe_o` is 1 from the completion of a read header until the first falling bus clock edge after the 16th data bit, or until select goes high. It is 0 during headers and during write data.
- R9: `req_valid_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n_i | input | 1 | Bus select pin, active low, asynchronous |
| bus_clk_i | input | 1 | Bus clock pin, asynchronous |
| bus_dat_i | input | 1 | Data pin input value |
| bus_dat_o | output | 1 | Data pin output value during read data |
| bus_dat_oe_o | output | 1 | Data pin output enable for the pad |
| dev_present_i | input | 8 | One bit per device number; 1 means a device is attached |
| req_valid_o | output | 1 | One-cycle register request strobe |
| req_dev_o | output | 3 | Device number of the request |
| req_reg_o | output | 5 | Register number of the request |
| req_rd_o | output | 1 | 1 for a read request, 0 for a write |
| req_wdata_o | output | 16 | Write data (0 on reads) |
| rd_data_i | input | 16 | Read data from the addressed device, sampled while `req_valid_o` is high |
| err_o | output | 1 | Sticky flag set by an access to an absent device |

## Verification
If the bit counter or the phase slips by one bit, the header fields show up shifted on the request port. A write request would then appear one bus clock early or late, or not at all, and the miscompare is visible within the same transaction. If the read word is loaded wrongly, or the turnaround is wrong, the serial data or the output enable is wrong on the very next bus clock edge. That is caught bit by bit, together with the enable level. A select that fails to reset the state shows up as misdecoded fields in the transaction that follows an aborted one. The bench sweeps every device number across a spread of registers and data patterns, so a decode fault or a presence fault has to show up in one of those transactions.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;
  localparam int DEV_W   = 3;
  localparam int REG_W   = 5;
  localparam int WORD_W  = 16;
  localparam int HDR_W   = DEV_W + 1 + REG_W;
  localparam int NDEV    = 1 << DEV_W;
  localparam int CNT_W   = $clog2(WORD_W);
  localparam int SYNC_N  = 2;

  typedef enum logic {PH_HDR = 1'b0, PH_DATA = 1'b1} phase_e;

  // field order mirrors header bit positions: dev in 8..6, rd in 5, reg in 4..0
  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic             rd;
    logic [REG_W-1:0] regn;
  } hdr_t;
endpackage

// File: rtl/tws_sync.sv
`timescale 1ns/1ps
module tws_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {STAGES{RST_VAL[i]}};
      else        st_q <= {st_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = st_q[STAGES-1];
  end
endmodule

// File: rtl/tws_engine.sv
`timescale 1ns/1ps
module tws_engine
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              dat_s,
  input  logic              load_rd_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              hdr_done_o,
  output hdr_t              hdr_o,
  output logic              wr_done_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic              dat_o,
  output logic              oe_o
);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  logic              sclk_q;
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              tx_q, tx_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              tail_q, tail_d;
  logic              dout_q, dout_d;

  logic              rise, fall;
  logic [WORD_W-1:0] shifted;

  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign shifted = {sh_q[WORD_W-2:0], dat_s};
  assign hdr_o     = hdr_t'(shifted[HDR_W-1:0]);
  assign wr_word_o = shifted;

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    tx_d       = tx_q;
    sh_d       = sh_q;
    oe_d       = oe_q;
    tail_d     = tail_q;
    dout_d     = dout_q;
    hdr_done_o = 1'b0;
    wr_done_o  = 1'b0;
    if (sel_s) begin
      phase_d = PH_HDR;
      cnt_d   = HDR_LAST;
      tx_d    = 1'b0;
      sh_d    = '0;
      oe_d    = 1'b0;
      tail_d  = 1'b0;
      dout_d  = 1'b0;
    end else begin
      if (load_rd_i) sh_d = rd_word_i;
      if (fall && tail_q) begin
        oe_d   = 1'b0;
        tail_d = 1'b0;
      end
      if (rise) begin
        if (phase_q == PH_HDR) begin
          oe_d   = 1'b0;
          tail_d = 1'b0;
          if (cnt_q == '0) begin
            hdr_done_o = 1'b1;
            phase_d    = PH_DATA;
            cnt_d      = WORD_LAST;
            tx_d       = hdr_o.rd;
            oe_d       = hdr_o.rd;
            sh_d       = '0;
          end else begin
            sh_d  = shifted;
            cnt_d = cnt_q - CNT_W'(1);
          end
        end else begin
          if (tx_q) dout_d = sh_q[cnt_q];
          else      sh_d   = shifted;
          if (cnt_q == '0) begin
            wr_done_o = ~tx_q;
            tail_d    = tx_q;
            phase_d   = PH_HDR;
            cnt_d     = HDR_LAST;
            tx_d      = 1'b0;
            sh_d      = '0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      phase_q <= PH_HDR;
      cnt_q   <= HDR_LAST;
      tx_q    <= 1'b0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      tail_q  <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      tail_q  <= tail_d;
      dout_q  <= dout_d;
    end
  end

  assign dat_o = dout_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/tws_req.sv
`timescale 1ns/1ps
module tws_req
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_done_i,
  input  hdr_t              hdr_i,
  input  logic              wr_done_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [NDEV-1:0]   dev_present_i,
  output logic              req_valid_o,
  output logic [DEV_W-1:0]  req_dev_o,
  output logic [REG_W-1:0]  req_reg_o,
  output logic              req_rd_o,
  output logic [WORD_W-1:0] req_wdata_o,
  output logic              err_o,
  output logic              load_rd_o
);
  logic              vld_q, vld_d;
  logic [DEV_W-1:0]  dev_q, dev_d;
  logic [REG_W-1:0]  reg_q, reg_d;
  logic              rd_q, rd_d;
  logic [WORD_W-1:0] wd_q, wd_d;
  logic              err_q, err_d;

  always_comb begin
    vld_d = 1'b0;
    dev_d = dev_q;
    reg_d = reg_q;
    rd_d  = rd_q;
    wd_d  = wd_q;
    err_d = err_q;
    if (hdr_done_i) begin
      dev_d = hdr_i.dev;
      reg_d = hdr_i.regn;
      rd_d  = hdr_i.rd;
      wd_d  = '0;
      if (hdr_i.rd) begin
        if (dev_present_i[hdr_i.dev]) vld_d = 1'b1;
        else                          err_d = 1'b1;
      end
    end else if (wr_done_i) begin
      rd_d = 1'b0;
      wd_d = wr_word_i;
      if (dev_present_i[dev_q]) vld_d = 1'b1;
      else                      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dev_q <= '0;
      reg_q <= '0;
      rd_q  <= 1'b0;
      wd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dev_q <= dev_d;
      reg_q <= reg_d;
      rd_q  <= rd_d;
      wd_q  <= wd_d;
      err_q <= err_d;
    end
  end

  assign req_valid_o = vld_q;
  assign req_dev_o   = dev_q;
  assign req_reg_o   = reg_q;
  assign req_rd_o    = rd_q;
  assign req_wdata_o = wd_q;
  assign err_o       = err_q;
  assign load_rd_o   = vld_q & rd_q;
endmodule

// File: rtl/tws_slave.sv
`timescale 1ns/1ps
module tws_slave
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n_i,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  output logic              bus_dat_o,
  output logic              bus_dat_oe_o,
  input  logic [NDEV-1:0]   dev_present_i,
  output logic              req_valid_o,
  output logic [DEV_W-1:0]  req_dev_o,
  output logic [REG_W-1:0]  req_reg_o,
  output logic              req_rd_o,
  output logic [WORD_W-1:0] req_wdata_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              err_o
);
  logic [2:0]        pins_s;
  logic              sel_s, sclk_s, dat_s;
  logic              hdr_done, wr_done, load_rd;
  hdr_t              hdr;
  logic [WORD_W-1:0] wr_word;

  tws_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({bus_sel_n_i, bus_clk_i, bus_dat_i}),
    .q_o   (pins_s)
  );
  assign sel_s  = pins_s[2];
  assign sclk_s = pins_s[1];
  assign dat_s  = pins_s[0];

  tws_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_s      (sel_s),
    .sclk_s     (sclk_s),
    .dat_s      (dat_s),
    .load_rd_i  (load_rd),
    .rd_word_i  (rd_data_i),
    .hdr_done_o (hdr_done),
    .hdr_o      (hdr),
    .wr_done_o  (wr_done),
    .wr_word_o  (wr_word),
    .dat_o      (bus_dat_o),
    .oe_o       (bus_dat_oe_o)
  );

  tws_req u_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .hdr_done_i    (hdr_done),
    .hdr_i         (hdr),
    .wr_done_i     (wr_done),
    .wr_word_i     (wr_word),
    .dev_present_i (dev_present_i),
    .req_valid_o   (req_valid_o),
    .req_dev_o     (req_dev_o),
    .req_reg_o     (req_reg_o),
    .req_rd_o      (req_rd_o),
    .req_wdata_o   (req_wdata_o),
    .err_o         (err_o),
    .load_rd_o     (load_rd)
  );
endmodule

// File: rtl/tws_slave_chk.sv
`timescale 1ns/1ps
module tws_slave_chk
  import tws_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sel_s,
  input logic             req_valid_o,
  input logic [DEV_W-1:0] req_dev_o,
  input logic [NDEV-1:0]  dev_present_i,
  input logic             bus_dat_oe_o,
  input logic             err_o
);
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> !req_valid_o);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  p_no_req_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> dev_present_i[req_dev_o]);

  p_oe_off_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> !bus_dat_oe_o);

  p_req_while_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> !$past(sel_s));
endmodule

bind tws_slave tws_slave_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel_s         (sel_s),
  .req_valid_o   (req_valid_o),
  .req_dev_o     (req_dev_o),
  .dev_present_i (dev_present_i),
  .bus_dat_oe_o  (bus_dat_oe_o),
  .err_o         (err_o)
);

// File: tb/tws_slave_tb_top.sv
`timescale 1ns/1ps
module tws_slave_tb_top;
  localparam int HALF = 6;
  localparam logic [7:0] PRESENT = 8'b1011_0110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel_n = 1'b1;
  logic        bus_clk = 1'b0;
  logic        bus_dat = 1'b0;
  logic        dat_o, oe_o, req_valid, req_rd, err;
  logic [2:0]  req_dev;
  logic [4:0]  req_reg;
  logic [15:0] req_wdata, rd_data;

  int vectors = 0;
  int fails = 0;
  int n_req = 0;
  bit done = 1'b0;
  logic [2:0]  last_dev;
  logic [4:0]  last_reg;
  logic        last_rd;
  logic [15:0] last_w;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rdfun(input logic [2:0] d, input logic [4:0] r);
    return 16'((16'(d) * 16'h1111) ^ (16'(r) * 16'h0403) ^ 16'hC35A);
  endfunction

  assign rd_data = rdfun(req_dev, req_reg);

  tws_slave dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel_n_i   (bus_sel_n),
    .bus_clk_i     (bus_clk),
    .bus_dat_i     (bus_dat),
    .bus_dat_o     (dat_o),
    .bus_dat_oe_o  (oe_o),
    .dev_present_i (PRESENT),
    .req_valid_o   (req_valid),
    .req_dev_o     (req_dev),
    .req_reg_o     (req_reg),
    .req_rd_o      (req_rd),
    .req_wdata_o   (req_wdata),
    .rd_data_i     (rd_data),
    .err_o         (err)
  );

  always @(posedge clk) begin
    if (rst_n && req_valid) begin
      n_req++;
      last_dev = req_dev;
      last_reg = req_reg;
      last_rd  = req_rd;
      last_w   = req_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    bus_dat = b; half();
    bus_clk = 1'b1; half();
    bus_clk = 1'b0;
  endtask

  task automatic get_bit(output logic b, output logic oe);
    bus_clk = 1'b1; half();
    b = dat_o; oe = oe_o;
    bus_clk = 1'b0; half();
  endtask

  task automatic sel_lo(); bus_sel_n = 1'b0; half(); endtask
  task automatic sel_hi(); bus_clk = 1'b0; bus_sel_n = 1'b1; half(); half(); endtask

  task automatic send_hdr(input logic [2:0] d, input logic rd, input logic [4:0] r);
    logic [8:0] h;
    h = {d, rd, r};
    for (int i = 8; i >= 0; i--) put_bit(h[i]);
    half();
  endtask

  // R3 / R8: read one word; checks enable during data and after it
  task automatic do_read(input logic [2:0] d, input logic [4:0] r, output logic [15:0] w);
    logic b, oe;
    send_hdr(d, 1'b1, r);
    for (int i = 15; i >= 0; i--) begin
      get_bit(b, oe);
      w[i] = b;
      chk(oe === 1'b1, "R8 oe high in read data", {31'd0, oe}, 32'd1);
    end
    chk(oe_o === 1'b0, "R8 oe low after final falling edge", {31'd0, oe_o}, 32'd0);
  endtask

  // R4: write one word; no request before the 16th bit
  task automatic do_write(input logic [2:0] d, input logic [4:0] r, input logic [15:0] w);
    int n0;
    send_hdr(d, 1'b0, r);
    chk(oe_o === 1'b0, "R8 oe low in write data", {31'd0, oe_o}, 32'd0);
    n0 = n_req;
    for (int i = 15; i >= 1; i--) put_bit(w[i]);
    half();
    chk(n_req == n0, "R4 no request before 16th bit", n_req, n0);
    put_bit(w[0]);
    half();
  endtask

  task automatic read_check(input logic [2:0] d, input logic [4:0] r);
    logic [15:0] got;
    int n0;
    n0 = n_req;
    do_read(d, r, got);
    chk(got === rdfun(d, r), "R3 read data", got, rdfun(d, r));
    chk(n_req == n0 + 1, "R3 one read request", n_req, n0 + 1);
    chk(last_rd === 1'b1, "R2 read flag", {31'd0, last_rd}, 32'd1);
    chk({last_dev, last_reg} === {d, r}, "R2 device/register fields", {last_dev, last_reg}, {d, r});
  endtask

  task automatic write_check(input logic [2:0] d, input logic [4:0] r, input logic [15:0] w);
    int n0;
    n0 = n_req;
    do_write(d, r, w);
    chk(n_req == n0 + 1, "R4 one write request", n_req, n0 + 1);
    chk(last_rd === 1'b0, "R4 write flag", {31'd0, last_rd}, 32'd0);
    chk(last_w === w, "R4 write data", last_w, w);
    chk({last_dev, last_reg} === {d, r}, "R2 write fields", {last_dev, last_reg}, {d, r});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [15:0] got;
    repeat (4) @(negedge clk);
    // R1 during and after reset
    chk({req_valid, oe_o, dat_o, err} === 4'b0, "R1 outputs in reset", {req_valid, oe_o, dat_o, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({req_valid, oe_o, dat_o, err} === 4'b0, "R1 outputs after reset", {req_valid, oe_o, dat_o, err}, 0);

    // R2 / R3 read sweep over present devices
    for (int d = 0; d < 8; d++) begin
      if (PRESENT[d]) begin
        for (int r = 0; r < 32; r += 5) begin
          sel_lo();
          read_check(3'(d), 5'(r));
          sel_hi();
        end
      end
    end

    // R4 write sweep
    for (int d = 0; d < 8; d++) begin
      if (PRESENT[d]) begin
        for (int k = 0; k < 4; k++) begin
          sel_lo();
          write_check(3'(d), 5'(k * 9 + d), 16'((16'h8001 << k) ^ (16'(d) * 16'h2D1B)));
          sel_hi();
        end
      end
    end

    // R6 back-to-back transactions under one select
    sel_lo();
    write_check(3'd1, 5'd3, 16'hFFFF);
    read_check(3'd2, 5'd7);
    write_check(3'd4, 5'd31, 16'h0000);
    read_check(3'd7, 5'd0);
    sel_hi();

    // R5 clock edges while select high are ignored
    n0 = n_req;
    for (int i = 0; i < 20; i++) begin
      bus_dat = i[0];
      half(); bus_clk = 1'b1; half(); bus_clk = 1'b0;
    end
    half();
    chk(n_req == n0, "R5 no request while deselected", n_req, n0);
    chk(oe_o === 1'b0, "R5 oe low while deselected", {31'd0, oe_o}, 32'd0);
    sel_lo();
    read_check(3'd5, 5'd9);
    sel_hi();

    // R5 abort mid-header, and mid-read
    sel_lo();
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    sel_hi();
    sel_lo();
    read_check(3'd4, 5'd22);
    sel_hi();
    sel_lo();
    send_hdr(3'd2, 1'b1, 5'd1);
    put_bit(1'b0);
    sel_hi();
    chk(oe_o === 1'b0, "R8 oe drops on select high", {31'd0, oe_o}, 32'd0);
    sel_lo();
    write_check(3'd2, 5'd6, 16'hA5C3);
    sel_hi();

    // R7 absent devices
    chk(err === 1'b0, "R7 no error yet", {31'd0, err}, 32'd0);
    n0 = n_req;
    sel_lo();
    do_read(3'd3, 5'd4, got);
    sel_hi();
    chk(got === 16'h0000, "R7 absent read returns zero", got, 0);
    chk(n_req == n0, "R7 no request to absent device", n_req, n0);
    chk(err === 1'b1, "R7 error set", {31'd0, err}, 32'd1);
    sel_lo();
    do_write(3'd6, 5'd2, 16'h1234);
    sel_hi();
    chk(n_req == n0, "R7 no write to absent device", n_req, n0);
    sel_lo();
    do_write(3'd0, 5'd2, 16'h4321);
    sel_hi();
    chk(n_req == n0, "R7 no write to device 0", n_req, n0);
    sel_lo();
    read_check(3'd1, 5'd17);
    sel_hi();
    chk(err === 1'b1, "R7 error sticky", {31'd0, err}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule